// File: doc/BRIEF.md
# Masked Alarm Repeat Comparator

This block holds four alarm registers (seconds, minutes, hours, day of month), each an 8-bit value. The top bit of each register is a repeat-mask flag and the lower bits a BCD number. A one-cycle tick strobe arrives once per second together with the current BCD time of day. On each strobe the block compares the unmasked alarm fields with the matching time fields, and on a match it raises a single-cycle interrupt pulse.

The pattern of mask flags picks the recurrence rate: monthly, daily, hourly, per minute or per second. Writes come through a small select/data port. A write whose BCD content is out of range for its field is dropped without any effect. Keeping time, battery backup and bus decoding belong to other blocks.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset `irq` is low, and no tick raises it until at least one alarm write has been accepted. A rejected write does not arm the alarm.
- R2: A write to seconds (`wrSel`=0) or minutes (`wrSel`=1) is stored only when both BCD digits of bits 6:0 are at most 9 and the value is 0 to 59. Otherwise the register keeps its old value.
- R3: A write to hours (`wrSel`=2) is stored only when bits 5:0 are valid BCD in the range 0 to 23. Otherwise the register is unchanged.
- R4: A write to date (`wrSel`=3) is stored only when bits 5:0 are valid BCD and not zero. Otherwise the register is unchanged.
- R5: With no mask flags set (bit 7 clear in all four registers), a tick fires only when date, hours, minutes and seconds all match.
- R6: With only the date mask set, a tick fires when hours, minutes and seconds match.
- R7: With the date and hour masks set and the others clear, a tick fires when minutes and seconds match.
- R8: With the date, hour and minute masks set and the seconds mask clear, a tick fires when seconds match.
- R9: Every other mask pattern, all four set included, fires on every tick.
- R10: `irq` is high for exactly one cycle, in the cycle after a tick that fired. It is never high without a tick one cycle earlier.
- R11: Masked fields and the unused upper bits of the time inputs take no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Alarm register write strobe |
| wrSel | input | 2 | Register select: 0 seconds, 1 minutes, 2 hours, 3 date |
| wrData | input | 8 | Bit 7 mask flag, lower bits BCD value |
| tick | input | 1 | One-cycle once-per-second strobe |
| curSec | input | 8 | Current seconds, BCD in bits 6:0 |
| curMin | input | 8 | Current minutes, BCD in bits 6:0 |
| curHour | input | 8 | Current hours, BCD in bits 5:0 |
| curDate | input | 8 | Current day of month, BCD in bits 5:0 |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
An accepted write changes its register at the clock edge where `wrEn` is sampled, so a tick issued in any later cycle already sees it. The interrupt register updates at the edge that samples `tick`. The bench therefore drives each tick on a falling edge, reads `irq` at the next falling edge, and reads it again one cycle later to confirm it has fallen. Range checks are observed through the interrupt: after each candidate write, a tick whose time equals the candidate fires only if the write was stored.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_FIELDS = 4;
  localparam int SEL_W    = $clog2(N_FIELDS);
  localparam int MASK_BIT = BYTE_W - 1;

  localparam logic [SEL_W-1:0] FLD_SEC  = 2'd0;
  localparam logic [SEL_W-1:0] FLD_MIN  = 2'd1;
  localparam logic [SEL_W-1:0] FLD_HOUR = 2'd2;
  localparam logic [SEL_W-1:0] FLD_DATE = 2'd3;

  typedef enum logic [2:0] {
    RATE_MONTH, RATE_DAY, RATE_HOUR, RATE_MINUTE, RATE_SECOND
  } rate_e;

  typedef struct packed {
    logic [N_FIELDS-1:0] load;
  } ctrlStrobe_t;

  // Value bits of a field: 7 for seconds/minutes, 6 for hours/date
  function automatic logic [BYTE_W-1:0] valueMask(input logic [SEL_W-1:0] sel);
    return (sel == FLD_SEC || sel == FLD_MIN) ? 8'h7F : 8'h3F;
  endfunction

  function automatic logic bcdFieldOk(input logic [BYTE_W-1:0] v,
                                      input logic [SEL_W-1:0] sel);
    logic [BYTE_W-1:0] f;
    int lo, hi, num;
    f   = v & valueMask(sel);
    lo  = int'(f[3:0]);
    hi  = int'(f[7:4]);
    num = hi * 10 + lo;
    if (lo > 9) return 1'b0;
    case (sel)
      FLD_SEC, FLD_MIN: return num <= 59;
      FLD_HOUR:         return num <= 23;
      default:          return num != 0;
    endcase
  endfunction
endpackage

// File: rtl/alarm_cmp_ctrl.sv
module alarm_cmp_ctrl
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              tick,
  input  logic              matchNow,
  output ctrlStrobe_t       strobe,
  output logic              irq
);
  logic accept;
  logic armed;

  assign accept = wrEn && bcdFieldOk(wrData, wrSel);

  always_comb begin
    strobe.load = '0;
    if (accept) strobe.load[wrSel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (accept) armed <= 1'b1;
      irq <= tick && armed && matchNow && !irq;
    end
  end

  // R10: single-cycle pulse
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R10: pulse only follows a tick
  p_irq_after_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(tick));
  // R1: quiet while disarmed
  p_quiet_disarmed_r1: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> armed);
  // R2: at most one register loads per write
  p_one_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.load));
endmodule

// File: rtl/alarm_cmp_datapath.sv
module alarm_cmp_datapath
  import alarm_cmp_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobe_t                      strobe,
  input  logic [BYTE_W-1:0]                wrData,
  input  logic [N_FIELDS-1:0][BYTE_W-1:0]  curTime,
  output logic                             matchNow
);
  logic [N_FIELDS-1:0][BYTE_W-1:0] alarmReg;
  logic [N_FIELDS-1:0]             maskBits;
  logic [N_FIELDS-1:0]             fieldEq;
  logic [N_FIELDS-1:0]             useField;
  rate_e                           rate;

  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_field
    localparam logic [BYTE_W-1:0] VMASK = valueMask(SEL_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                alarmReg[gi] <= '0;
      else if (strobe.load[gi]) alarmReg[gi] <= wrData;
    end

    assign maskBits[gi] = alarmReg[gi][MASK_BIT];
    assign fieldEq[gi]  = (alarmReg[gi] & VMASK) == (curTime[gi] & VMASK);

    // R2: a register without a load strobe keeps its value
    p_hold_unloaded_r2: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load[gi] |=> $stable(alarmReg[gi]));
  end

  always_comb begin
    unique case (maskBits)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MINUTE;
      default: rate = RATE_SECOND;
    endcase
  end

  always_comb begin
    case (rate)
      RATE_MONTH:  useField = 4'b1111;
      RATE_DAY:    useField = 4'b0111;
      RATE_HOUR:   useField = 4'b0011;
      RATE_MINUTE: useField = 4'b0001;
      default:     useField = 4'b0000;
    endcase
  end

  assign matchNow = &(fieldEq | ~useField);

  // R9: per-second rate matches regardless of time
  p_every_second_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rate == RATE_SECOND) |-> matchNow);
  // R5: monthly rate with a date mismatch never matches
  p_month_date_r5: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == 4'b0000 && !fieldEq[FLD_DATE]) |-> !matchNow);
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              tick,
  input  logic [BYTE_W-1:0] curSec,
  input  logic [BYTE_W-1:0] curMin,
  input  logic [BYTE_W-1:0] curHour,
  input  logic [BYTE_W-1:0] curDate,
  output logic              irq
);
  ctrlStrobe_t                     strobe;
  logic                            matchNow;
  logic [N_FIELDS-1:0][BYTE_W-1:0] curTime;

  assign curTime = {curDate, curHour, curMin, curSec};

  alarm_cmp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tick(tick), .matchNow(matchNow), .strobe(strobe), .irq(irq)
  );

  alarm_cmp_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .curTime(curTime), .matchNow(matchNow)
  );
endmodule

// File: tb/alarm_cmp_top_tb_top.sv
module alarm_cmp_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic       tick = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDate = '0;
  logic       irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  alarm_cmp_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tick(tick), .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .curDate(curDate), .irq(irq)
  );

  function automatic bit refOk(input int sel, input int v);
    int lo, hi, num;
    lo = v & 15;
    hi = (sel < 2) ? ((v >> 4) & 7) : ((v >> 4) & 3);
    num = hi * 10 + lo;
    if (lo > 9) return 0;
    if (sel < 2) return num <= 59;
    if (sel == 2) return num <= 23;
    return num != 0;
  endfunction

  task automatic check(input bit got, input bit exp, input string req);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: irq=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = 8'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // tick with a given time, check pulse and its fall one cycle later
  task automatic tickAt(input int s, input int m, input int h, input int d,
                        input bit exp, input string req);
    @(negedge clk);
    curSec = 8'(s); curMin = 8'(m); curHour = 8'(h); curDate = 8'(d);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(irq, exp, req);
    @(negedge clk);
    if (exp) check(irq, 1'b0, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int base[4];
    int alt[4];
    int used;
    bit exp;
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    check(irq, 1'b0, "R1");
    // all-zero registers vs all-zero time would match monthly; disarmed
    tickAt(0, 0, 0, 0, 1'b0, "R1");
    wr(3, 8'h00);                       // rejected date write: stays disarmed
    tickAt(0, 0, 0, 0, 1'b0, "R1");

    // R2 seconds sweep, per-minute mode
    wr(3, 8'h81); wr(2, 8'h81); wr(1, 8'h81);
    for (int v = 0; v < 128; v++) begin
      wr(0, 8'h25); wr(0, v);
      tickAt(v, 0, 0, 0, refOk(0, v) || v == 8'h25, "R2");
      tickAt(8'h25, 0, 0, 0, !refOk(0, v) || v == 8'h25, "R2");
    end
    // R11 upper time bit ignored for seconds
    wr(0, 8'h33);
    tickAt(8'hB3, 8'h77, 8'h55, 8'h66, 1'b1, "R11");

    // R2 minutes sweep, hourly mode
    wr(0, 8'h10);
    wr(2, 8'h81);
    for (int v = 0; v < 128; v++) begin
      wr(1, 8'h25); wr(1, v);
      tickAt(8'h10, v, 0, 0, refOk(1, v) || v == 8'h25, "R2");
    end

    // R3 hours sweep, daily mode
    wr(1, 8'h10); wr(3, 8'h81); wr(0, 8'h10);
    for (int v = 0; v < 64; v++) begin
      wr(2, 8'h12); wr(2, v);
      tickAt(8'h10, 8'h10, v, 0, refOk(2, v) || v == 8'h12, "R3");
    end

    // R4 date sweep, monthly mode
    wr(2, 8'h05);
    for (int v = 0; v < 64; v++) begin
      wr(3, 8'h12); wr(3, v);
      tickAt(8'h10, 8'h10, 8'h05, v, refOk(3, v) || v == 8'h12, "R4");
    end

    // R5..R9 and R11: every mask pattern against a one-field mismatch
    base = '{8'h11, 8'h22, 8'h03, 8'h14};
    alt  = '{8'h12, 8'h23, 8'h04, 8'h15};
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 4; f++) wr(f, base[f] | (((m >> f) & 1) << 7));
      case (m)
        0:  used = 4'b1111;
        8:  used = 4'b0111;
        12: used = 4'b0011;
        14: used = 4'b0001;
        default: used = 4'b0000;
      endcase
      for (int f = 0; f <= 4; f++) begin
        int t[4];
        string req;
        t = base;
        if (f < 4) t[f] = alt[f];
        exp = (f == 4) || !((used >> f) & 1);
        case (m)
          0: req = "R5"; 8: req = "R6"; 12: req = "R7"; 14: req = "R8";
          default: req = "R9";
        endcase
        if (f < 4 && !((used >> f) & 1)) req = {req, "/R11"};
        tickAt(t[0], t[1], t[2], t[3], exp, req);
      end
    end

    // R10: no pulse without a tick even when time matches
    @(negedge clk);
    curSec = 8'h11; curMin = 8'h22; curHour = 8'h03; curDate = 8'h14;
    repeat (3) begin
      @(negedge clk);
      check(irq, 1'b0, "R10");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule